// File: doc/BRIEF.md
# Dual-Zone Secure Memory Access Filter

This block sits in front of on-chip secure RAM blocks and flash sectors. It judges every access in the cycle it is presented and either forwards it to the memory or suppresses it. A suppressed read hands the requester a zero word in that same cycle. A suppressed write simply never reaches the memory. The filter never stalls an access.

Ownership of each RAM block and flash sector is worked out from a pair of two-bit grab fields, one field per zone. Two sectors are tied to fixed zones, whatever their fields say. The verdict depends on four things: who owns the target address, who owns the address of the instruction now executing, whether the owning zone is locked, and whether the request comes from the CPU or from the debug port.

Both zones start locked. Each zone opens on its own when a 128-bit key, presented as four 32-bit words, equals that zone's stored password. The address map is fixed. Address bits [ADDR_W-1:ADDR_W-2] select the region: 01 is RAM and 10 is flash. Any other value is unsecure memory. The block or sector index sits at bit BLK_AW and up. Read data from the memory is taken to be valid in the same cycle as the request.

Top module: `csm_access_filter`

## Requirements
- R1: After reset both zones are locked (`lock_o` = 2'b11, bit 0 is zone 1). A lock bit never returns to 1 except through reset.
- R2: Accesses to unsecure regions (region bits 00 or 11), and to RAM blocks whose two fields are both 11, are forwarded for every requester and every executing address.
- R3: A RAM block or sector is inaccessible in two cases: either field is 00, or both fields are in {01,10}. An inaccessible block is never forwarded, for any requester or executing address.
- R4: A zone-1 field of 11 with a zone-2 field of 01 or 10 gives the block to zone 1. A zone-1 field of 01 or 10 with a zone-2 field of 11 gives it to zone 2.
- R5: Flash sector N_SECT-1 always belongs to zone 1 and sector 0 always belongs to zone 2, regardless of their grab fields.
- R6: If the owning zone is locked and the executing address is in that zone, a CPU access is forwarded and a debug access is blocked.
- R7: If the owning zone is locked and the executing address is outside that zone, both CPU and debug accesses are blocked.
- R8: If the owning zone is unlocked, every requester's access is forwarded.
- R9: A blocked read returns zero on `rsp_rdata_o` in the same cycle, and the next access is handled normally. A forwarded read returns `mem_rdata_i` in the same cycle.
- R10: A blocked write asserts neither `mem_req_o` nor `mem_we_o`.
- R11: A compare cycle clears a zone's lock bit at the next clock edge only if all four key words equal that zone's password (`cmp_zone_i` 0 selects zone 1, 1 selects zone 2). A single wrong word leaves the zone locked.
- R12: Unlocking one zone does not change how the other zone's memory is treated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_dbg_i | input | 1 | 1 when the access comes from the debug port |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| pc_i | input | ADDR_W | Address of the executing instruction |
| z1_ram_grab_i | input | 2*N_RAM | Zone-1 RAM grab fields, block g at [2g+1:2g] |
| z2_ram_grab_i | input | 2*N_RAM | Zone-2 RAM grab fields |
| z1_sect_grab_i | input | 2*N_SECT | Zone-1 sector grab fields, sector s at [2s+1:2s] |
| z2_sect_grab_i | input | 2*N_SECT | Zone-2 sector grab fields |
| z1_key_i | input | PW_W | Zone-1 stored password |
| z2_key_i | input | PW_W | Zone-2 stored password |
| cmp_valid_i | input | 1 | Password compare strobe |
| cmp_zone_i | input | 1 | Compare target: 0 zone 1, 1 zone 2 |
| cmp_word_i | input | PW_W | Four candidate key words |
| mem_req_o | output | 1 | Forwarded access strobe |
| mem_we_o | output | 1 | Forwarded write strobe |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, same cycle |
| rsp_rdata_o | output | DATA_W | Read data to the requester |
| lock_o | output | 2 | Lock state per zone |

## Verification
A password compare that unlocks a zone can land in the same cycle as an access to that zone's memory. The access must still be judged on the old lock state, and only the access in the following cycle sees the new one. The bench drives a correct compare together with a debug read of the zone. It expects that read to be blocked and the read one cycle later to be forwarded. Random runs also mix compare strobes with accesses on every clock, and the reference model's lock state changes only at the edge.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [1:0] {OWN_OPEN, OWN_Z1, OWN_Z2, OWN_DEAD} owner_e;

  localparam logic [1:0] RGN_RAM   = 2'b01;
  localparam logic [1:0] RGN_FLASH = 2'b10;
  localparam logic [1:0] GRAB_NONE = 2'b00;
  localparam logic [1:0] GRAB_FULL = 2'b11;

  // pair of zone fields -> owner
  function automatic owner_e grab_decode(input logic [1:0] f1, input logic [1:0] f2);
    if (f1 == GRAB_NONE || f2 == GRAB_NONE) return OWN_DEAD;
    if (f1 == GRAB_FULL && f2 == GRAB_FULL) return OWN_OPEN;
    if (f1 == GRAB_FULL) return OWN_Z1;
    if (f2 == GRAB_FULL) return OWN_Z2;
    return OWN_DEAD;
  endfunction
endpackage

// File: rtl/csm_owner_decode.sv
module csm_owner_decode
  import csm_pkg::*;
#(
  parameter int N_RAM   = 4,
  parameter int N_SECT  = 8,
  parameter int RAM_IW  = 2,
  parameter int SECT_IW = 3,
  parameter int Z1_SECT = N_SECT - 1,
  parameter int Z2_SECT = 0
) (
  input  logic [1:0]          region_i,
  input  logic [RAM_IW-1:0]   ram_idx_i,
  input  logic [SECT_IW-1:0]  sect_idx_i,
  input  logic [2*N_RAM-1:0]  z1_ram_grab_i,
  input  logic [2*N_RAM-1:0]  z2_ram_grab_i,
  input  logic [2*N_SECT-1:0] z1_sect_grab_i,
  input  logic [2*N_SECT-1:0] z2_sect_grab_i,
  output owner_e              owner_o
);
  owner_e ram_own  [N_RAM];
  owner_e sect_own [N_SECT];

  for (genvar g = 0; g < N_RAM; g++) begin : g_ram
    assign ram_own[g] = grab_decode(z1_ram_grab_i[2*g +: 2], z2_ram_grab_i[2*g +: 2]);
  end

  for (genvar g = 0; g < N_SECT; g++) begin : g_sect
    if (g == Z1_SECT) begin : g_fix_z1
      assign sect_own[g] = OWN_Z1;
    end else if (g == Z2_SECT) begin : g_fix_z2
      assign sect_own[g] = OWN_Z2;
    end else begin : g_grab
      assign sect_own[g] = grab_decode(z1_sect_grab_i[2*g +: 2], z2_sect_grab_i[2*g +: 2]);
    end
  end

  always_comb begin
    case (region_i)
      RGN_RAM:   owner_o = ram_own[ram_idx_i];
      RGN_FLASH: owner_o = sect_own[sect_idx_i];
      default:   owner_o = OWN_OPEN;
    endcase
  end
endmodule

// File: rtl/csm_zone_lock.sv
module csm_zone_lock #(
  parameter int PW_W   = 128,
  parameter int WORD_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmp_en_i,
  input  logic [PW_W-1:0] key_i,
  input  logic [PW_W-1:0] cand_i,
  output logic            locked_o
);
  localparam int N_WORDS = PW_W / WORD_W;

  logic [N_WORDS-1:0] word_eq;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign word_eq[w] = (key_i[w*WORD_W +: WORD_W] == cand_i[w*WORD_W +: WORD_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   locked_o <= 1'b1;
    else if (cmp_en_i && &word_eq) locked_o <= 1'b0;
  end
endmodule

// File: rtl/csm_access_policy.sv
module csm_access_policy
  import csm_pkg::*;
(
  input  owner_e     tgt_own_i,
  input  owner_e     pc_own_i,
  input  logic       dbg_i,
  input  logic [1:0] locked_i,
  output logic       permit_o
);
  logic zone_locked;

  always_comb begin
    case (tgt_own_i)
      OWN_Z1:  zone_locked = locked_i[0];
      OWN_Z2:  zone_locked = locked_i[1];
      default: zone_locked = 1'b0;
    endcase
  end

  always_comb begin
    case (tgt_own_i)
      OWN_OPEN: permit_o = 1'b1;
      OWN_DEAD: permit_o = 1'b0;
      // locked: only CPU code running from the same zone gets through
      default:  permit_o = !zone_locked || (!dbg_i && (pc_own_i == tgt_own_i));
    endcase
  end
endmodule

// File: rtl/csm_access_filter.sv
module csm_access_filter
  import csm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int N_RAM  = 4,
  parameter int N_SECT = 8,
  parameter int BLK_AW = 8,
  parameter int PW_W   = 128,
  parameter int WORD_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic                req_dbg_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [2*N_RAM-1:0]  z1_ram_grab_i,
  input  logic [2*N_RAM-1:0]  z2_ram_grab_i,
  input  logic [2*N_SECT-1:0] z1_sect_grab_i,
  input  logic [2*N_SECT-1:0] z2_sect_grab_i,
  input  logic [PW_W-1:0]     z1_key_i,
  input  logic [PW_W-1:0]     z2_key_i,
  input  logic                cmp_valid_i,
  input  logic                cmp_zone_i,
  input  logic [PW_W-1:0]     cmp_word_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [1:0]          lock_o
);
  localparam int RAM_IW  = (N_RAM  > 1) ? $clog2(N_RAM)  : 1;
  localparam int SECT_IW = (N_SECT > 1) ? $clog2(N_SECT) : 1;
  localparam int N_ZONES = 2;

  owner_e tgt_own;
  owner_e pc_own;
  logic   permit;
  logic   unused_pc;

  logic [N_ZONES-1:0][PW_W-1:0] zone_key;
  assign zone_key = {z2_key_i, z1_key_i};

  csm_owner_decode #(
    .N_RAM(N_RAM), .N_SECT(N_SECT), .RAM_IW(RAM_IW), .SECT_IW(SECT_IW)
  ) i_tgt_dec (
    .region_i       (req_addr_i[ADDR_W-1 -: 2]),
    .ram_idx_i      (req_addr_i[BLK_AW +: RAM_IW]),
    .sect_idx_i     (req_addr_i[BLK_AW +: SECT_IW]),
    .z1_ram_grab_i  (z1_ram_grab_i),
    .z2_ram_grab_i  (z2_ram_grab_i),
    .z1_sect_grab_i (z1_sect_grab_i),
    .z2_sect_grab_i (z2_sect_grab_i),
    .owner_o        (tgt_own)
  );

  csm_owner_decode #(
    .N_RAM(N_RAM), .N_SECT(N_SECT), .RAM_IW(RAM_IW), .SECT_IW(SECT_IW)
  ) i_pc_dec (
    .region_i       (pc_i[ADDR_W-1 -: 2]),
    .ram_idx_i      (pc_i[BLK_AW +: RAM_IW]),
    .sect_idx_i     (pc_i[BLK_AW +: SECT_IW]),
    .z1_ram_grab_i  (z1_ram_grab_i),
    .z2_ram_grab_i  (z2_ram_grab_i),
    .z1_sect_grab_i (z1_sect_grab_i),
    .z2_sect_grab_i (z2_sect_grab_i),
    .owner_o        (pc_own)
  );
  assign unused_pc = ^pc_i;

  for (genvar z = 0; z < N_ZONES; z++) begin : g_zone
    csm_zone_lock #(.PW_W(PW_W), .WORD_W(WORD_W)) i_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmp_en_i (cmp_valid_i && (cmp_zone_i == 1'(z))),
      .key_i    (zone_key[z]),
      .cand_i   (cmp_word_i),
      .locked_o (lock_o[z])
    );
  end

  csm_access_policy i_policy (
    .tgt_own_i (tgt_own),
    .pc_own_i  (pc_own),
    .dbg_i     (req_dbg_i),
    .locked_i  (lock_o),
    .permit_o  (permit)
  );

  assign mem_req_o   = req_valid_i && permit;
  assign mem_we_o    = mem_req_o && req_we_i;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;
  assign rsp_rdata_o = (mem_req_o && !req_we_i) ? mem_rdata_i : '0;
endmodule

// File: rtl/csm_access_filter_chk.sv
module csm_access_filter_chk
  import csm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int N_SECT = 8,
  parameter int BLK_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic              req_dbg_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              cmp_valid_i,
  input logic              cmp_zone_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [1:0]        lock_o,
  input owner_e            tgt_own
);
  localparam int SECT_IW = (N_SECT > 1) ? $clog2(N_SECT) : 1;

  p_no_relock_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(lock_o[0]) && !$rose(lock_o[1]));

  p_dead_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_own == OWN_DEAD) |-> !mem_req_o);

  p_fixed_sect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_addr_i[ADDR_W-1 -: 2] == RGN_FLASH &&
     req_addr_i[BLK_AW +: SECT_IW] == SECT_IW'(N_SECT-1)) |-> (tgt_own == OWN_Z1));

  p_dbg_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && req_dbg_i) |-> (tgt_own == OWN_OPEN ||
      (tgt_own == OWN_Z1 && !lock_o[0]) || (tgt_own == OWN_Z2 && !lock_o[1])));

  p_blocked_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && !mem_req_o) |-> (rsp_rdata_o == '0));

  p_blocked_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && !mem_req_o) |-> !mem_we_o);

  p_unlock_z1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o[0]) |-> $past(cmp_valid_i && !cmp_zone_i));

  p_unlock_z2_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o[1]) |-> $past(cmp_valid_i && cmp_zone_i));
endmodule

bind csm_access_filter csm_access_filter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SECT(N_SECT), .BLK_AW(BLK_AW)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_dbg_i   (req_dbg_i),
  .req_addr_i  (req_addr_i),
  .cmp_valid_i (cmp_valid_i),
  .cmp_zone_i  (cmp_zone_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .rsp_rdata_o (rsp_rdata_o),
  .lock_o      (lock_o),
  .tgt_own     (tgt_own)
);

// File: tb/test_csm_access_filter.sv
module test_csm_access_filter;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NR = 4;
  localparam int NS = 8;
  localparam logic [127:0] K1 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] K2 = 128'h5a5a_1111_c3c3_2222_0f0f_3333_9696_4444;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_we, req_dbg, cmp_valid, cmp_zone;
  logic [AW-1:0] req_addr, pc, mem_addr;
  logic [DW-1:0] req_wdata, mem_wdata, mem_rdata, rsp_rdata;
  logic [2*NR-1:0] z1_ram, z2_ram;
  logic [2*NS-1:0] z1_sect, z2_sect;
  logic [127:0] cmp_word;
  logic mem_req, mem_we;
  logic [1:0] lock;

  assign mem_rdata = {~mem_addr, mem_addr};

  csm_access_filter i_csm_access_filter (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_dbg_i(req_dbg), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .pc_i(pc),
    .z1_ram_grab_i(z1_ram), .z2_ram_grab_i(z2_ram),
    .z1_sect_grab_i(z1_sect), .z2_sect_grab_i(z2_sect),
    .z1_key_i(K1), .z2_key_i(K2), .cmp_valid_i(cmp_valid), .cmp_zone_i(cmp_zone),
    .cmp_word_i(cmp_word), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rsp_rdata_o(rsp_rdata), .lock_o(lock)
  );

  int compared = 0;
  int mismatched = 0;
  string cur_tag = "R1";
  logic [1:0] ref_lock;

  // reference model: 0 open, 1 zone1, 2 zone2, 3 dead
  function automatic int pair_owner(logic [1:0] a, logic [1:0] b);
    if (a == 2'b00 || b == 2'b00) return 3;
    if (a == 2'b11) return (b == 2'b11) ? 0 : 1;
    if (b == 2'b11) return 2;
    return 3;
  endfunction

  function automatic int owner_of(logic [AW-1:0] a);
    int i;
    if (a[15:14] == 2'b01) begin
      i = int'(a[9:8]);
      return pair_owner(z1_ram[2*i +: 2], z2_ram[2*i +: 2]);
    end
    if (a[15:14] == 2'b10) begin
      i = int'(a[10:8]);
      if (i == NS-1) return 1;
      if (i == 0) return 2;
      return pair_owner(z1_sect[2*i +: 2], z2_sect[2*i +: 2]);
    end
    return 0;
  endfunction

  function automatic bit ref_permit();
    int o;
    o = owner_of(req_addr);
    if (o == 0) return 1'b1;
    if (o == 3) return 1'b0;
    if (!ref_lock[o-1]) return 1'b1;
    if (req_dbg) return 1'b0;
    return owner_of(pc) == o;
  endfunction

  function automatic string auto_tag();
    int o;
    o = owner_of(req_addr);
    if (o == 0) return "R2";
    if (o == 3) return "R3";
    if (!ref_lock[o-1]) return "R8";
    if (owner_of(pc) == o) return "R6";
    return "R7";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_lock <= 2'b11;
    else if (cmp_valid) begin
      if (!cmp_zone && cmp_word == K1) ref_lock[0] <= 1'b0;
      if (cmp_zone && cmp_word == K2)  ref_lock[1] <= 1'b0;
    end
  end

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns before the rising edge
  always @(negedge clk) begin
    bit p;
    string t;
    #4;
    p = ref_permit();
    t = (cur_tag != "") ? cur_tag : auto_tag();
    check("R1", "lock", DW'(lock), DW'(ref_lock));
    check(t, "mem_req", DW'(mem_req), DW'(req_valid & p));
    check("R10", "mem_we", DW'(mem_we), DW'(req_valid & p & req_we));
    check(req_we ? t : "R9", "rdata", rsp_rdata,
          (req_valid && p && !req_we) ? {~req_addr, req_addr} : '0);
  end

  task automatic acc(string tag, logic we, logic dbg, logic [AW-1:0] a, logic [AW-1:0] p);
    @(negedge clk);
    cur_tag = tag; req_valid = 1'b1; req_we = we; req_dbg = dbg;
    req_addr = a; pc = p; req_wdata = {a, ~a};
  endtask

  task automatic cmp(string tag, logic z, logic [127:0] w);
    @(negedge clk);
    cur_tag = tag; cmp_valid = 1'b1; cmp_zone = z; cmp_word = w;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic rand_phase(int n, bit good_keys);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = "";
      req_valid = 1'($urandom); req_we = 1'($urandom); req_dbg = 1'($urandom);
      req_addr = AW'($urandom); pc = AW'($urandom); req_wdata = $urandom;
      if (i % 40 == 0) begin
        z1_ram = 8'($urandom); z2_ram = 8'($urandom);
        z1_sect = 16'($urandom); z2_sect = 16'($urandom);
      end
      cmp_valid = ($urandom % 16) == 0;
      cmp_zone = 1'($urandom);
      cmp_word = (good_keys && ($urandom % 4 == 0)) ? (cmp_zone ? K2 : K1)
                                                     : {$urandom, $urandom, $urandom, $urandom};
    end
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_dbg = 1'b0;
    req_addr = '0; pc = '0; req_wdata = '0; cmp_valid = 1'b0; cmp_zone = 1'b0; cmp_word = '0;
    // blk0 open, blk1 zone1 (11/01), blk2 zone2 (10/11), blk3 dead (00/11)
    z1_ram = 8'b00_10_11_11; z2_ram = 8'b11_11_01_11;
    // s7 fixed z1 (00/00), s6..4 dead, s3 open, s2 z2, s1 z1, s0 fixed z2 (11/11)
    z1_sect = 16'h2ADF; z2_sect = 16'h15FB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    acc("R2", 0, 1, 16'h0123, 16'h0000);
    acc("R2", 0, 1, 16'h4010, 16'h0000);
    acc("R3", 0, 0, 16'h4310, 16'h4310);
    acc("R3", 1, 0, 16'h4320, 16'h4100);
    acc("R4", 0, 0, 16'h4110, 16'h4120);
    acc("R4", 0, 0, 16'h4210, 16'h4220);
    acc("R6", 0, 1, 16'h4110, 16'h4120);
    acc("R7", 0, 0, 16'h4110, 16'h0040);
    acc("R7", 0, 0, 16'h4110, 16'h4220);
    acc("R5", 0, 0, 16'h8710, 16'h8700);
    acc("R5", 0, 0, 16'h8710, 16'h8140);
    acc("R5", 0, 0, 16'h8710, 16'h8040);
    acc("R5", 0, 0, 16'h8010, 16'h8240);
    acc("R9", 0, 0, 16'h4110, 16'h0000);
    acc("R9", 0, 0, 16'h0456, 16'h0000);
    acc("R10", 1, 1, 16'h4110, 16'h4100);
    // blk3 now 01/10: both mismatched values -> dead
    z1_ram[7:6] = 2'b01; z2_ram[7:6] = 2'b10;
    acc("R3", 0, 0, 16'h4330, 16'h4330);
    // one wrong word keeps zone 1 locked
    acc("R11", 0, 1, 16'h4110, 16'h0000);
    cmp("R11", 1'b0, K1 ^ {32'h0, 32'h0, 32'h0000_0100, 32'h0});
    acc("R11", 0, 1, 16'h4110, 16'h0000);
    cmp("R11", 1'b1, K1);
    acc("R11", 0, 1, 16'h4110, 16'h0000);
    // correct compare in the same cycle as a debug read of zone 1
    cmp("R11", 1'b0, K1);
    acc("R8", 0, 1, 16'h4110, 16'h0000);
    acc("R8", 1, 1, 16'h8710, 16'h0000);
    acc("R12", 0, 1, 16'h4210, 16'h0000);
    acc("R12", 0, 0, 16'h4210, 16'h4110);
    rand_phase(3000, 1'b0);
    cmp("R11", 1'b1, K2);
    acc("R12", 0, 1, 16'h4210, 16'h0000);
    rand_phase(3000, 1'b1);
    @(negedge clk);
    cur_tag = "R1"; rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rand_phase(3000, 1'b1);
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule